// File: doc/BRIEF.md
# Video Blank Event Generator

This block produces the timing events of a raster display from the system clock. A horizontal period counter and a vertical period counter run all the time. Each marks the start of a blanking interval when its period wraps. It marks the end of that interval half a period later. From these events the block drives two level gates for downstream timers, two one-cycle pulses for the interrupt controller, a small display status word and a single display interrupt line.

Software selects the timing family with a two-bit input. Bit 0 picks the PAL line and frame lengths instead of NTSC. Bit 1 picks the interlaced frame length and affects only the vertical counter. Software also writes a status word and an interrupt mask through one shared write-data bus, each with its own strobe. A status interrupt fires at most once for each time software arms it.

Each counter is sequenced by a two-state phase machine. PH_WAIT moves to PH_BLANK on the period boundary, and PH_BLANK moves back to PH_WAIT at the half-period point. Each interrupt channel has a two-state arm machine. ARM_OFF moves to ARM_ON when software writes 1 to the channel's status bit. ARM_ON moves back to ARM_OFF when the channel's blank-end event occurs, unless a new arming write lands in the same cycle.

Top module: `blank_event_gen`

## Requirements
- R1: `hblank_gate` rises on the clock edge that completes each horizontal period of Ph cycles, counted from reset (edge Ph, 2Ph, ...). It falls Ph/2 edges later, so it is high for exactly Ph/2 cycles.
- R2: `vblank_gate` behaves like the horizontal gate but with the vertical period Pv. `ic_vstart` is a one-cycle pulse on every edge where `vblank_gate` rises (interrupt-controller line 2).
- R3: A vertical blank end is recognised only after a vertical blank start. `ic_vend` is a one-cycle pulse on each edge where `vblank_gate` falls (interrupt-controller line 3). No end pulse occurs before the first start.
- R4: `timing_sel[0]`=1 selects the PAL periods, and 0 selects NTSC. `timing_sel[1]`=1 selects the interlaced vertical period. The horizontal period ignores `timing_sel[1]`.
- R5: `status[13]` is the field bit. It is 0 after reset, toggles at every vertical blank end and changes at no other time.
- R6: `status[2]` is set at each horizontal blank end and `status[3]` at each vertical blank end. Each stays set until a `csr_wr` with 1 in that bit of `sw_wdata` clears it. If an event and a clearing write land in the same cycle, the event wins. All other status bits read 0.
- R7: A `csr_wr` with `sw_wdata[2]` (horizontal) or `sw_wdata[3]` (vertical) set arms that channel. An armed channel whose mask bit is 0 raises `disp_irq` for one cycle at the next blank end of that channel. The channel is then disarmed.
- R8: A blank end on an armed but masked channel still disarms it. No interrupt is raised then or after a later unmask, until software arms the channel again.
- R9: `msk_wr` loads mask bit 10 (horizontal) and mask bit 11 (vertical) from `sw_wdata`. After reset both channels are masked.
- R10: During reset both gates, all pulses, `disp_irq` and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_sel | input | 2 | Bit 0: PAL/NTSC periods, bit 1: interlaced vertical period |
| csr_wr | input | 1 | Status write strobe (write 1 to bit 2/3 clears the flag and arms the channel) |
| msk_wr | input | 1 | Mask write strobe (loads bits 10 and 11) |
| sw_wdata | input | 16 | Shared software write data |
| status | output | 16 | Bit 2 horizontal flag, bit 3 vertical flag, bit 13 field |
| disp_irq | output | 1 | One-cycle display interrupt |
| ic_vstart | output | 1 | One-cycle pulse at vertical blank start |
| ic_vend | output | 1 | One-cycle pulse at vertical blank end |
| hblank_gate | output | 1 | High during horizontal blank |
| vblank_gate | output | 1 | High during vertical blank |

## Verification
The timing outputs are swept cycle by cycle over all four `timing_sel` codes. The sweep runs for more than three frames, with every expected value worked out from the edge count modulo the chosen period. Because the two PAL/NTSC periods differ, the sweep tells apart a wrong bit-0 decode, and the interlace settings show whether bit 1 wrongly reaches the horizontal counter. The reset-to-first-start stretch shows any end pulse raised before a start. A directed sequence then arms the channels while masked, unmasks after a consumed event, rearms, and clears flags with writes. Its interrupt counts separate a channel that fires once from one that fires repeatedly, never fires, or keeps its arm through a masked event.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_BLANK = 1'b1
    } phase_e;

    typedef enum logic {
        ARM_OFF = 1'b0,
        ARM_ON  = 1'b1
    } arm_e;

    localparam int NCH       = 2;   // channel 0 horizontal, channel 1 vertical
    localparam int HFLAG_BIT = 2;
    localparam int VFLAG_BIT = 3;
    localparam int HMASK_BIT = 10;
    localparam int VMASK_BIT = 11;
    localparam int FIELD_BIT = 13;
    localparam int SW_W      = 16;

    function automatic int bits_for(input int v);
        return $clog2(v + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vbg_phase_ctr.sv
module vbg_phase_ctr
    import vbg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    output logic         start_evt,
    output logic         end_evt,
    output logic         gate
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] half;
    phase_e       st_q;
    phase_e       st_d;

    // Event decode and next state. Compares use >= so that a period
    // shrinking under a running count still produces a boundary.
    always_comb begin
        half      = period >> 1;
        start_evt = (cnt_q >= period - W'(1));
        end_evt   = (st_q == PH_BLANK) && !start_evt && (cnt_q >= half - W'(1));
        st_d      = st_q;
        unique case (st_q)
            PH_WAIT:  if (start_evt) st_d = PH_BLANK;
            PH_BLANK: if (end_evt)   st_d = PH_WAIT;
            default:  st_d = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            st_q  <= PH_WAIT;
        end else begin
            cnt_q <= start_evt ? '0 : cnt_q + W'(1);
            st_q  <= st_d;
        end
    end

    always_comb begin
        gate = (st_q == PH_BLANK);
    end

endmodule

// File: rtl/vbg_status.sv
module vbg_status
    import vbg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_end,
    input  logic            v_start,
    input  logic            v_end,
    input  logic            csr_wr,
    input  logic            msk_wr,
    input  logic [SW_W-1:0] sw_wdata,
    output logic [SW_W-1:0] status,
    output logic            disp_irq,
    output logic            ic_vstart,
    output logic            ic_vend
);

    logic [NCH-1:0] ev;
    logic [NCH-1:0] fire;
    logic [NCH-1:0] flags;
    logic           field_q;
    logic           irq_q;
    logic           vstart_q;
    logic           vend_q;

    assign ev = {v_end, h_end};

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            localparam int SB = (i == 0) ? HFLAG_BIT : VFLAG_BIT;
            localparam int MB = (i == 0) ? HMASK_BIT : VMASK_BIT;

            arm_e arm_q;
            arm_e arm_d;
            logic wr_hit;
            logic flag_q;
            logic mask_q;

            always_comb begin
                wr_hit = csr_wr && sw_wdata[SB];
                arm_d  = arm_q;
                unique case (arm_q)
                    ARM_OFF: if (wr_hit)            arm_d = ARM_ON;
                    ARM_ON:  if (ev[i] && !wr_hit)  arm_d = ARM_OFF;
                    default: arm_d = ARM_OFF;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    arm_q  <= ARM_OFF;
                    flag_q <= 1'b0;
                    mask_q <= 1'b1;
                end else begin
                    arm_q  <= arm_d;
                    flag_q <= ev[i] | (flag_q & ~wr_hit);
                    if (msk_wr) mask_q <= sw_wdata[MB];
                end
            end

            assign fire[i]  = (arm_q == ARM_ON) && ev[i] && !mask_q;
            assign flags[i] = flag_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q  <= 1'b0;
            irq_q    <= 1'b0;
            vstart_q <= 1'b0;
            vend_q   <= 1'b0;
        end else begin
            field_q  <= field_q ^ v_end;
            irq_q    <= |fire;
            vstart_q <= v_start;
            vend_q   <= v_end;
        end
    end

    always_comb begin
        status            = '0;
        status[HFLAG_BIT] = flags[0];
        status[VFLAG_BIT] = flags[1];
        status[FIELD_BIT] = field_q;
        disp_irq          = irq_q;
        ic_vstart         = vstart_q;
        ic_vend           = vend_q;
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = &{1'b0, sw_wdata};

endmodule

// File: rtl/blank_event_gen.sv
module blank_event_gen
    import vbg_pkg::*;
#(
    parameter int H_NTSC    = 9370,
    parameter int H_PAL     = 9436,
    parameter int V_NTSC    = 4489020,
    parameter int V_PAL     = 4717970,
    parameter int V_NTSC_IL = 2244510,
    parameter int V_PAL_IL  = 2358986
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  timing_sel,
    input  logic        csr_wr,
    input  logic        msk_wr,
    input  logic [15:0] sw_wdata,
    output logic [15:0] status,
    output logic        disp_irq,
    output logic        ic_vstart,
    output logic        ic_vend,
    output logic        hblank_gate,
    output logic        vblank_gate
);

    localparam int HW = bits_for(max2(H_NTSC, H_PAL));
    localparam int VW = bits_for(max2(max2(V_NTSC, V_PAL), max2(V_NTSC_IL, V_PAL_IL)));

    logic [HW-1:0] h_period;
    logic [VW-1:0] v_period;
    logic          h_start;
    logic          h_end;
    logic          v_start;
    logic          v_end;

    always_comb begin
        h_period = timing_sel[0] ? HW'(H_PAL) : HW'(H_NTSC);
        unique case (timing_sel)
            2'b00:   v_period = VW'(V_NTSC);
            2'b01:   v_period = VW'(V_PAL);
            2'b10:   v_period = VW'(V_NTSC_IL);
            default: v_period = VW'(V_PAL_IL);
        endcase
    end

    vbg_phase_ctr #(.W(HW)) u_hphase (
        .clk       (clk),
        .rst_n     (rst_n),
        .period    (h_period),
        .start_evt (h_start),
        .end_evt   (h_end),
        .gate      (hblank_gate)
    );

    vbg_phase_ctr #(.W(VW)) u_vphase (
        .clk       (clk),
        .rst_n     (rst_n),
        .period    (v_period),
        .start_evt (v_start),
        .end_evt   (v_end),
        .gate      (vblank_gate)
    );

    vbg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_end     (h_end),
        .v_start   (v_start),
        .v_end     (v_end),
        .csr_wr    (csr_wr),
        .msk_wr    (msk_wr),
        .sw_wdata  (sw_wdata),
        .status    (status),
        .disp_irq  (disp_irq),
        .ic_vstart (ic_vstart),
        .ic_vend   (ic_vend)
    );

    logic unused_hstart;
    assign unused_hstart = h_start;

endmodule

// File: rtl/blank_event_gen_chk.sv
module blank_event_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_h,
    input logic        h_flag,
    input logic        v_flag,
    input logic        field,
    input logic        disp_irq,
    input logic        ic_vstart,
    input logic        ic_vend,
    input logic        hblank_gate,
    input logic        vblank_gate
);

    // R2: start pulse coincides with the vertical gate being high
    a_r2_vstart_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ic_vstart |-> vblank_gate);

    // R2: start pulse lasts one cycle
    a_r2_vstart_single: assert property (@(posedge clk) disable iff (!rst_n)
        ic_vstart |=> !ic_vstart);

    // R3: end pulse only where the vertical gate falls
    a_r3_vend_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ic_vend |-> $fell(vblank_gate));

    // R5: field toggles at vertical end
    a_r5_field_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        ic_vend |-> (field != $past(field)));

    // R5: field holds otherwise
    a_r5_field_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ic_vend |-> $stable(field));

    // R6: horizontal flag rises only at horizontal blank end
    a_r6_hflag_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_flag) |-> $fell(hblank_gate));

    // R6: vertical flag rises only at vertical blank end
    a_r6_vflag_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_flag) |-> ic_vend);

    // R6: horizontal flag drops only after a clearing write
    a_r6_hflag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_flag) |-> $past(clr_h));

    // R7: interrupt only at a blank end
    a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        disp_irq |-> ($fell(hblank_gate) || ic_vend));

endmodule

bind blank_event_gen blank_event_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_h       (csr_wr && sw_wdata[2]),
    .h_flag      (status[2]),
    .v_flag      (status[3]),
    .field       (status[13]),
    .disp_irq    (disp_irq),
    .ic_vstart   (ic_vstart),
    .ic_vend     (ic_vend),
    .hblank_gate (hblank_gate),
    .vblank_gate (vblank_gate)
);

// File: tb/blank_event_gen_bench.sv
`timescale 1ns/1ps
module blank_event_gen_bench;

    localparam int HN  = 10;
    localparam int HP  = 12;
    localparam int VN  = 40;
    localparam int VP  = 48;
    localparam int VNI = 20;
    localparam int VPI = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  timing_sel = 2'b00;
    logic        csr_wr = 1'b0;
    logic        msk_wr = 1'b0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] status;
    logic        disp_irq;
    logic        ic_vstart;
    logic        ic_vend;
    logic        hblank_gate;
    logic        vblank_gate;

    int k = 0;
    int nvec = 0;
    int nmis = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    blank_event_gen #(
        .H_NTSC(HN), .H_PAL(HP), .V_NTSC(VN), .V_PAL(VP),
        .V_NTSC_IL(VNI), .V_PAL_IL(VPI)
    ) u_blank_event_gen (
        .clk(clk), .rst_n(rst_n), .timing_sel(timing_sel),
        .csr_wr(csr_wr), .msk_wr(msk_wr), .sw_wdata(sw_wdata),
        .status(status), .disp_irq(disp_irq), .ic_vstart(ic_vstart),
        .ic_vend(ic_vend), .hblank_gate(hblank_gate), .vblank_gate(vblank_gate)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nmis++;
            $display("FAIL %s at k=%0d: got %0d expected %0d", tag, k, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        timing_sel = sel;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset gates/pulses/irq",
              int'({hblank_gate, vblank_gate, ic_vstart, ic_vend, disp_irq}), 0);
        check("R10 reset status", int'(status), 0);
        rst_n = 1'b1;
    endtask

    // Cycle-by-cycle sweep with no software activity
    task automatic run_sweep(input logic [1:0] sel);
        int ph;
        int pv;
        int limit;
        ph = sel[0] ? HP : HN;   // R4: horizontal ignores bit 1
        case (sel)
            2'b00:   pv = VN;
            2'b01:   pv = VP;
            2'b10:   pv = VNI;
            default: pv = VPI;
        endcase
        do_reset(sel);
        limit = 3 * pv + pv / 2 + 2;
        while (k < limit) begin
            int eh, ev, evs, eve, nend, est;
            bit bad;
            @(negedge clk);
            eh   = (k >= ph) && (k % ph < ph / 2);
            ev   = (k >= pv) && (k % pv < pv / 2);
            evs  = (k > 0) && (k % pv == 0);
            eve  = (k > pv) && (k % pv == pv / 2);
            nend = (k >= pv + pv / 2) ? (k - pv / 2) / pv : 0;
            est  = ((k >= ph + ph / 2) ? 4 : 0) + ((k >= pv + pv / 2) ? 8 : 0)
                 + ((nend % 2) * 8192);
            bad = (int'(hblank_gate) != eh) || (int'(vblank_gate) != ev) ||
                  (int'(ic_vstart) != evs) || (int'(ic_vend) != eve) ||
                  (int'(status) != est) || disp_irq;
            nvec++;
            if (bad) begin
                nmis++;
                if (int'(hblank_gate) != eh)
                    $display("FAIL R1/R4 hgate sel=%0d k=%0d: got %0d expected %0d", sel, k, hblank_gate, eh);
                if (int'(vblank_gate) != ev)
                    $display("FAIL R2/R4 vgate sel=%0d k=%0d: got %0d expected %0d", sel, k, vblank_gate, ev);
                if (int'(ic_vstart) != evs)
                    $display("FAIL R2 vstart sel=%0d k=%0d: got %0d expected %0d", sel, k, ic_vstart, evs);
                if (int'(ic_vend) != eve)
                    $display("FAIL R3 vend sel=%0d k=%0d: got %0d expected %0d", sel, k, ic_vend, eve);
                if (int'(status) != est)
                    $display("FAIL R5/R6 status sel=%0d k=%0d: got %0h expected %0h", sel, k, status, est);
                if (disp_irq)
                    $display("FAIL R7 unarmed irq sel=%0d k=%0d: got 1 expected 0", sel, k);
            end
        end
    endtask

    task automatic write_at(input int n, input logic c, input logic m, input logic [15:0] d);
        while (k != n) @(negedge clk);
        csr_wr = c;
        msk_wr = m;
        sw_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        msk_wr = 1'b0;
        sw_wdata = '0;
    endtask

    task automatic count_irq(input int upto, output int cnt, output int firstk);
        cnt = 0;
        firstk = -1;
        while (k < upto) begin
            @(negedge clk);
            if (disp_irq) begin
                cnt++;
                if (firstk < 0) firstk = k;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nmis++;
            $display("FAIL watchdog expired: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int f;
        for (int s = 0; s < 4; s++) run_sweep(2'(s));

        // Directed interrupt sequence, NTSC non-interlaced: Ph=10, Pv=40.
        // Horizontal ends at k=15,25,...; vertical ends at k=60,100,140.
        do_reset(2'b00);
        write_at(2, 1'b1, 1'b0, 16'h0004);        // arm H while masked
        count_irq(20, c, f);
        check("R9 masked after reset, no irq", c, 0);
        write_at(21, 1'b0, 1'b1, 16'h0000);       // unmask both
        count_irq(30, c, f);
        check("R8 arm consumed by masked end", c, 0);
        write_at(31, 1'b1, 1'b0, 16'h0004);       // rearm H
        count_irq(40, c, f);
        check("R7 single H irq count", c, 1);
        check("R7 H irq timing", f, 35);
        check("R6 hflag set", int'(status[2]), 1);
        write_at(41, 1'b1, 1'b1, 16'h040C);       // arm both, mask H
        check("R6 hflag cleared by write", int'(status[2]), 0);
        count_irq(46, c, f);
        check("R9 H masked via bit 10", c, 0);
        check("R6 hflag set again", int'(status[2]), 1);
        count_irq(61, c, f);
        check("R7 single V irq count", c, 1);
        check("R7 V irq timing", f, 60);
        check("R6 vflag set", int'(status[3]), 1);
        write_at(62, 1'b0, 1'b1, 16'h0000);       // unmask H
        count_irq(100, c, f);
        check("R8 no irq after unmask without rearm", c, 0);
        write_at(101, 1'b1, 1'b0, 16'h000C);      // arm both
        count_irq(140, c, f);
        check("R7 both channels fire once each", c, 2);
        check("R7 first irq at H end", f, 105);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule